// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This controller sits on the host side of a byte-wide parallel EEPROM and turns a stream of write requests into correctly timed strobe sequences. Each request carries an address and a data byte and is taken through a valid/ready handshake. For every accepted byte the sequencer drives the address and data buses, waits a setup interval, pulls chip select and write enable low together for the minimum pulse width, then keeps the buses steady for a hold interval. Output enable stays high the whole time.

Requests that keep arriving and that stay on the same page are issued back to back. Their strobe falling edges therefore stay well inside the device's page window. A burst ends when the requester has no byte ready at the decision cycle, or when the next byte belongs to another page. The sequencer then holds off all new work for the worst-case programming time, with `busy` high and `ready` low.

All intervals are given in nanoseconds together with the clock period. Each one is rounded up to a whole number of clock cycles, with a minimum of one.

Top module: `eeprom_page_writer`

## Requirements
- R1: `ee_oe_n` is 1 in every cycle after reset.
- R2: `ee_cs_n` and `ee_we_n` always carry the same value. Each low pulse lasts exactly PULSE = ceil(T_PULSE_NS/CLK_PERIOD_NS) cycles.
- R3: The address and data of a byte are on `ee_addr`/`ee_data` at least one cycle before the strobes fall. They stay unchanged while the strobes are low and for HOLD = ceil(T_HOLD_NS/CLK_PERIOD_NS) cycles after the strobes rise.
- R4: Within one burst, consecutive strobe falling edges are PULSE+HOLD+1+SETUP cycles apart, where SETUP = ceil(T_SETUP_NS/CLK_PERIOD_NS). This spacing times the clock period is below T_WINDOW_NS.
- R5: If `req_valid` is low in the decision cycle that follows a byte's hold interval, the burst ends and the programming wait starts.
- R6: A request whose page field `req_addr[ADDR_W-1:PAGE_BITS]` differs from the burst's page is refused in the decision cycle (`req_ready` low). The burst ends, and the request is accepted only after the programming wait.
- R7: The programming wait keeps `busy` high for exactly PROG = ceil(T_PROG_NS/CLK_PERIOD_NS) cycles, after which the block is idle with `req_ready` high.
- R8: `req_ready` is low while `busy` is high and during the setup, strobe and hold phases of a byte. Accepted bytes appear on the buses in acceptance order, one strobe pulse each.
- R9: After reset `ee_cs_n`, `ee_we_n` and `ee_oe_n` are 1, `busy` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request taken this cycle when valid is also high |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | DATA_W | Byte to write |
| busy | output | 1 | High during the programming wait |
| ee_addr | output | ADDR_W | Registered address bus to the EEPROM |
| ee_data | output | DATA_W | Registered data bus to the EEPROM |
| ee_cs_n | output | 1 | Chip select, active low |
| ee_we_n | output | 1 | Write enable, active low |
| ee_oe_n | output | 1 | Output enable, held high |

## Verification
The assertions assume that `req_addr` and `req_data` stay fixed while `req_valid` is high and the request has not yet been taken. They also assume the timing parameters make the in-burst strobe spacing fall below the page window. The stimulus only changes a request on the falling clock edge that follows its acceptance. The bench overrides the timing parameters with values whose back-to-back spacing (15 cycles) is far below the 99-cycle window limit. The programming interval (2005 ns) is chosen so that rounding up to 201 cycles is exercised.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DECIDE,
    ST_PROG
  } eepw_state_e;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // Largest cycle count whose duration is strictly shorter than the window.
  function automatic int unsigned win_limit_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eepw_phase_timer.sv
module eepw_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/eepw_page_track.sv
module eepw_page_track #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              same_page
);
  localparam int unsigned PW = ADDR_W - PAGE_BITS;

  logic [PW-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (capture) page_q <= probe_addr[ADDR_W-1:PAGE_BITS];
  end

  assign same_page = (probe_addr[ADDR_W-1:PAGE_BITS] == page_q);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PAGE_BITS     = 7,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_SETUP_NS    = 10,
  parameter int unsigned T_PULSE_NS    = 100,
  parameter int unsigned T_HOLD_NS     = 10,
  parameter int unsigned T_WINDOW_NS   = 150000,
  parameter int unsigned T_PROG_NS     = 10000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [DATA_W-1:0] ee_data,
  output logic              ee_cs_n,
  output logic              ee_we_n,
  output logic              ee_oe_n
);
  localparam int unsigned SETUP_CYC = ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(T_HOLD_NS,  CLK_PERIOD_NS);
  localparam int unsigned PROG_CYC  = ns_to_cyc(T_PROG_NS,  CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   =
    max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, PROG_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  eepw_state_e st_q, st_nxt;

  // Named internal events, visible to the bound checker.
  logic accept_evt;
  logic burst_end_evt;
  logic same_page;
  logic phase_done;
  logic phase_load;

  function automatic logic [CNT_W-1:0] phase_len(input eepw_state_e s);
    case (s)
      ST_SETUP:  return CNT_W'(SETUP_CYC - 1);
      ST_STROBE: return CNT_W'(PULSE_CYC - 1);
      ST_HOLD:   return CNT_W'(HOLD_CYC - 1);
      ST_PROG:   return CNT_W'(PROG_CYC - 1);
      default:   return '0;
    endcase
  endfunction

  eepw_page_track #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept_evt),
    .probe_addr(req_addr),
    .same_page (same_page)
  );

  eepw_phase_timer #(
    .W(CNT_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (phase_load),
    .load_val(phase_len(st_nxt)),
    .done    (phase_done)
  );

  assign req_ready     = (st_q == ST_IDLE) || ((st_q == ST_DECIDE) && same_page);
  assign accept_evt    = req_valid && req_ready;
  assign burst_end_evt = (st_q == ST_DECIDE) && !accept_evt;
  assign phase_load    = (st_nxt != st_q);

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE:   if (accept_evt) st_nxt = ST_SETUP;
      ST_SETUP:  if (phase_done) st_nxt = ST_STROBE;
      ST_STROBE: if (phase_done) st_nxt = ST_HOLD;
      ST_HOLD:   if (phase_done) st_nxt = ST_DECIDE;
      ST_DECIDE: st_nxt = accept_evt ? ST_SETUP : ST_PROG;
      ST_PROG:   if (phase_done) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ee_addr <= '0;
      ee_data <= '0;
      ee_cs_n <= 1'b1;
      ee_we_n <= 1'b1;
    end else begin
      st_q    <= st_nxt;
      ee_cs_n <= (st_nxt != ST_STROBE);
      ee_we_n <= (st_nxt != ST_STROBE);
      if (accept_evt) begin
        ee_addr <= req_addr;
        ee_data <= req_data;
      end
    end
  end

  assign busy    = (st_q == ST_PROG);
  assign ee_oe_n = 1'b1;
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker
  import eepw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_PULSE_NS    = 100,
  parameter int unsigned T_WINDOW_NS   = 150000,
  parameter int unsigned T_PROG_NS     = 10000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              burst_end_evt,
  input logic [ADDR_W-1:0] ee_addr,
  input logic [DATA_W-1:0] ee_data,
  input logic              ee_cs_n,
  input logic              ee_we_n,
  input logic              ee_oe_n
);
  localparam int unsigned PULSE_CYC = ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned PROG_CYC  = ns_to_cyc(T_PROG_NS, CLK_PERIOD_NS);
  localparam int unsigned WIN_LIM   = win_limit_cyc(T_WINDOW_NS, CLK_PERIOD_NS);

  logic        prev_we;
  logic        in_page;
  logic        fall_evt;
  int unsigned low_cnt, busy_cnt, gap_cnt;

  assign fall_evt = prev_we && !ee_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we  <= 1'b1;
      in_page  <= 1'b0;
      low_cnt  <= 0;
      busy_cnt <= 0;
      gap_cnt  <= 0;
    end else begin
      prev_we  <= ee_we_n;
      low_cnt  <= ee_we_n ? 0 : low_cnt + 1;
      busy_cnt <= busy ? busy_cnt + 1 : 0;
      if (fall_evt)                   gap_cnt <= 1;
      else if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1;
      if (busy)          in_page <= 1'b0;
      else if (fall_evt) in_page <= 1'b1;
    end
  end

  assert_oe_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |-> ee_oe_n);

  assert_strobes_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_n == ee_we_n);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_we_n) |-> low_cnt >= PULSE_CYC);

  assert_bus_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_we_n) |-> ($stable(ee_addr) && $stable(ee_data)));

  assert_bus_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |=> ($stable(ee_addr) && $stable(ee_data)));

  assert_page_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && in_page) |-> gap_cnt <= WIN_LIM);

  assert_wait_follows_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end_evt |=> busy);

  assert_prog_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == PROG_CYC);

  assert_no_ready_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_no_strobe_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ee_we_n);
endmodule

bind eeprom_page_writer eepw_checker #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_PULSE_NS   (T_PULSE_NS),
  .T_WINDOW_NS  (T_WINDOW_NS),
  .T_PROG_NS    (T_PROG_NS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .busy         (busy),
  .burst_end_evt(burst_end_evt),
  .ee_addr      (ee_addr),
  .ee_data      (ee_data),
  .ee_cs_n      (ee_cs_n),
  .ee_we_n      (ee_we_n),
  .ee_oe_n      (ee_oe_n)
);

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int CLKNS = 10;

  // Expected cycle counts, rounded up by repeated subtraction.
  function automatic int cycles_of(input int ns);
    int c = 0;
    int left = ns;
    while (left > 0) begin left -= CLKNS; c++; end
    return (c < 1) ? 1 : c;
  endfunction

  localparam int T_SETUP = 20, T_PULSE = 100, T_HOLD = 15, T_WIN = 1000, T_PROG = 2005;

  int pulse_c, hold_c, setup_c, prog_c, gap_c;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, busy, ee_cs_n, ee_we_n, ee_oe_n;
  logic [AW-1:0] ee_addr;
  logic [DW-1:0] ee_data;

  always #5 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(4), .CLK_PERIOD_NS(CLKNS),
    .T_SETUP_NS(T_SETUP), .T_PULSE_NS(T_PULSE), .T_HOLD_NS(T_HOLD),
    .T_WINDOW_NS(T_WIN), .T_PROG_NS(T_PROG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .ee_addr(ee_addr), .ee_data(ee_data), .ee_cs_n(ee_cs_n),
    .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n)
  );

  int n_checks = 0, n_fail = 0;
  bit reported = 0;
  logic [AW+DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Monitor / scoreboard state
  int oe_low = 0, pair_bad = 0, rdy_bad = 0, stable_bad = 0;
  int gap = 0, low = 0, hold_left = 0, bcnt = 0, busy_periods = 0, writes = 0;
  bit gap_armed = 0, prev_we = 1, prev_busy = 0;
  logic [AW-1:0] prev_addr = '0, fall_addr = '0;
  logic [DW-1:0] prev_data = '0, fall_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_oe_n !== 1'b1) oe_low++;
      if (ee_cs_n !== ee_we_n) pair_bad++;
      if (busy && req_ready) rdy_bad++;
      gap++;
      if (prev_we && !ee_we_n) begin
        if (gap_armed) chk(gap == gap_c, "R4 fall-to-fall spacing", gap, gap_c);
        chk(ee_addr == prev_addr && ee_data == prev_data, "R3 bus set before strobe",
            int'(ee_addr), int'(prev_addr));
        gap = 0; gap_armed = 1; low = 1;
        fall_addr = ee_addr; fall_data = ee_data;
      end else if (!ee_we_n) begin
        low++;
        if (ee_addr != fall_addr || ee_data != fall_data) stable_bad++;
      end else if (!prev_we && ee_we_n) begin
        chk(low == pulse_c, "R2 strobe low width", low, pulse_c);
        if (ee_addr != fall_addr || ee_data != fall_data) stable_bad++;
        if (exp_q.size() == 0) chk(0, "R8 write without request", int'(ee_addr), -1);
        else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          chk({ee_addr, ee_data} == e, "R8 write order/content",
              int'({ee_addr, ee_data}), int'(e));
        end
        hold_left = hold_c;
        writes++;
      end else if (hold_left > 0) begin
        hold_left--;
        if (ee_addr != fall_addr || ee_data != fall_data) stable_bad++;
      end
      if (busy) bcnt++;
      else if (prev_busy) begin
        chk(bcnt == prog_c, "R7 busy length", bcnt, prog_c);
        busy_periods++;
        bcnt = 0;
      end
      if (busy) gap_armed = 0;
      prev_we = ee_we_n; prev_busy = busy; prev_addr = ee_addr; prev_data = ee_data;
    end
  end

  // Driver: present a request, wait for ready, record it as expected.
  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back({a, d});
    @(posedge clk);
  endtask

  task automatic drop;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_busy(input int n);
    while (busy_periods < n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    pulse_c = cycles_of(T_PULSE);
    hold_c  = cycles_of(T_HOLD);
    setup_c = cycles_of(T_SETUP);
    prog_c  = cycles_of(T_PROG);
    gap_c   = pulse_c + hold_c + 1 + setup_c;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R9 reset state
    chk(ee_cs_n == 1 && ee_we_n == 1, "R9 strobes high after reset", int'(ee_we_n), 1);
    chk(ee_oe_n == 1, "R9 oe high after reset", int'(ee_oe_n), 1);
    chk(busy == 0 && req_ready == 1, "R9 idle and ready after reset", int'(busy), 0);

    // Single byte
    send(12'h010, 8'hA5);
    @(negedge clk); req_valid = 0; #1;
    chk(req_ready == 0, "R8 ready low in setup phase", int'(req_ready), 0);
    wait_busy(1);
    chk(req_ready == 1 && busy == 0, "R7 idle and ready after wait", int'(req_ready), 1);

    // Same-page burst of four
    send(12'h020, 8'h11);
    send(12'h021, 8'h22);
    send(12'h022, 8'h33);
    send(12'h023, 8'h44);
    drop();
    wait_busy(2);
    chk(writes == 5, "R4 burst bytes written in one page", writes, 5);

    // Page crossing: third byte is on the next page
    send(12'h03E, 8'h55);
    send(12'h03F, 8'h66);
    send(12'h040, 8'h77);
    chk(busy_periods == 3, "R6 new page taken only after wait", busy_periods, 3);
    drop();
    wait_busy(4);

    // Valid dropped before the decision cycle ends the burst
    send(12'h050, 8'h88);
    drop();
    wait_busy(5);
    chk(writes == 9 && busy_periods == 5, "R5 burst ended by idle requester", writes, 9);
    send(12'h051, 8'h99);
    drop();
    wait_busy(6);

    chk(writes == 10 && exp_q.size() == 0, "R8 every request written once", writes, 10);
    chk(oe_low == 0, "R1 output enable never low", oe_low, 0);
    chk(pair_bad == 0, "R2 chip select matches write enable", pair_bad, 0);
    chk(stable_bad == 0, "R3 bus stable through pulse and hold", stable_bad, 0);
    chk(rdy_bad == 0, "R8 ready low while busy", rdy_bad, 0);
    chk(gap_c * CLKNS < T_WIN, "R4 spacing below page window", gap_c * CLKNS, T_WIN);
    report();
  end
endmodule